// File: doc/BRIEF.md
# Infrared Remote Carrier Modulator

This block drives an infrared emitter from a queue of self-timed instruction words. Software writes 32-bit words into a small transmit queue. Each word says whether it should be executed. It also says whether the emitter is active or idle, whether an active period carries the modulated carrier or a steady high level, and how many bit-clock periods the word lasts. A sequencer takes the words one after another with no gap between them. A carrier generator makes the modulation waveform from separate high-time and low-time counts. A bit-clock divider sets the length of one duration unit.

Timing values are written into shadow registers and take effect at the next safe point: the carrier period boundary for the carrier counts, and the next bit tick (or at once while idle) for the divider. A busy flag marks each update until it has been taken. Five interrupt sources report frame completion, queue underflow and queue fill-level changes. Each source has its own enable, acknowledge and force controls. A count of zero in a duration, carrier time or divider is executed as one.

Top module: `ir_carrier_mod`

## Requirements
- R1: A word written to address 0 whose bit 31 is 0 is removed from the queue without being executed, and the output stays low.
- R2: A valid word with bit 30 = 0 holds the output low for its whole duration. A valid word with bits 30 = 1 and 29 = 1 holds the output high for its whole duration.
- R3: A valid word with bit 30 = 1 and bit 29 = 0 gates the carrier onto the output. The carrier is high for the count at address 1 and low for the count at address 2, both in core-clock cycles. Every such word restarts the carrier at the beginning of a full high phase.
- R4: A word lasts its duration field (bits 17:0) times the divider at address 3, in core-clock cycles. Queued words follow one another with no idle cycle between them.
- R5: When no word is executing, the output is low.
- R6: The queue holds DEPTH words. Address 4 reads the fill level in bits 7:0, empty in bit 8, full in bit 9 and at-most-half-full in bit 10. A push into a full queue is dropped.
- R7: The raw interrupt bits at address 6 are set in this order: bit 0 frame end, bit 1 queue became full, bit 2 underflow, bit 3 queue became empty, bit 4 queue became at most half full. The queue-level sources are set on entry into their condition, and all raw bits stay set until acknowledged.
- R8: When a word ends and no valid word follows, frame end is raised. If the queue was empty at that point, underflow is raised as well. An invalid word that follows at that point ends the frame without an underflow.
- R9: Writing ones to address 8 sets enables, to address 9 clears enables, to address 10 clears raw bits, and to address 11 sets raw bits. Address 7 reads the enables and address 5 reads raw AND enable. The irq output is high when any bit at address 5 is set.
- R10: Address 12 reads the pending-update flags: bit 0 carrier high count, bit 1 carrier low count, bit 2 divider. A flag is set by a write and clears once the value has been taken into use.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 32 | Register read data (combinational) |
| ir_out | output | 1 | Emitter drive |
| irq | output | 1 | Interrupt request |

## Verification
The hardest situation to reach is the hand-over between two words. The next word must already be queued when the current one expires, so that the carrier restart and the no-gap rule can be seen, and the terminator-versus-underflow choice depends on what sits at the head of the queue in that exact cycle. The bench reaches it by pushing the follow-on words in the cycles right after the first word has been taken, in a branch that runs alongside the output sampler, so the queue is never empty at the boundary. The full-queue case is reached by holding one long word in execution while the queue is filled behind it.

// File: rtl/ir_mod_pkg.sv
package ir_mod_pkg;
   localparam int WORD_W     = 32;
   localparam int DUR_W      = 18;
   localparam int VALID_BIT  = 31;
   localparam int ACTIVE_BIT = 30;
   localparam int FORCE_BIT  = 29;
   localparam int NUM_IRQ    = 5;
   localparam int ENTRY_W    = DUR_W + 3;

   localparam int IRQ_FRAME_END = 0;
   localparam int IRQ_FULL      = 1;
   localparam int IRQ_UNDERFLOW = 2;
   localparam int IRQ_EMPTY     = 3;
   localparam int IRQ_HALF      = 4;

   typedef enum logic [3:0] {
      A_PUSH      = 4'd0,
      A_CARR_HI   = 4'd1,
      A_CARR_LO   = 4'd2,
      A_BIT_DIV   = 4'd3,
      A_FIFO_STAT = 4'd4,
      A_IRQ_PEND  = 4'd5,
      A_IRQ_RAW   = 4'd6,
      A_IRQ_EN    = 4'd7,
      A_EN_SET    = 4'd8,
      A_EN_CLR    = 4'd9,
      A_IRQ_ACK   = 4'd10,
      A_IRQ_FORCE = 4'd11,
      A_UPD_BUSY  = 4'd12
   } reg_addr_e;

   typedef struct packed {
      logic             valid;
      logic             active;
      logic             forced;
      logic [DUR_W-1:0] dur;
   } instr_t;

   function automatic instr_t pack_word(input logic [WORD_W-1:0] w);
      instr_t r;
      r.valid  = w[VALID_BIT];
      r.active = w[ACTIVE_BIT];
      r.forced = w[FORCE_BIT];
      r.dur    = w[DUR_W-1:0];
      return r;
   endfunction
endpackage

// File: rtl/ir_tx_fifo.sv
module ir_tx_fifo #(
   parameter int DEPTH = 8,
   parameter int W     = 21,
   localparam int PTR_W = $clog2(DEPTH),
   localparam int LVL_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [W-1:0]     din,
   input  logic             pop,
   output logic [W-1:0]     dout,
   output logic [LVL_W-1:0] level,
   output logic             empty,
   output logic             full,
   output logic             half
);
   localparam logic [LVL_W-1:0] FULL_CNT = LVL_W'(DEPTH);
   localparam logic [LVL_W-1:0] HALF_CNT = LVL_W'(DEPTH / 2);

   initial begin
      depth_pow2_chk: assert ((DEPTH >= 2) && ((DEPTH & (DEPTH - 1)) == 0))
         else $error("ir_tx_fifo: DEPTH must be a power of two, at least 2");
   end

   logic [W-1:0]     mem [DEPTH];
   logic [PTR_W-1:0] wp, rp;
   logic [LVL_W-1:0] cnt;
   logic             push_ok, pop_ok;

   assign empty   = (cnt == '0);
   assign full    = (cnt == FULL_CNT);
   assign half    = (cnt <= HALF_CNT);
   assign level   = cnt;
   assign dout    = mem[rp];
   assign push_ok = push && !full;
   assign pop_ok  = pop && !empty;

   always_ff @(posedge clk) begin
      if (push_ok) mem[wp] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else begin
         if (push_ok) wp <= wp + 1'b1;
         if (pop_ok)  rp <= rp + 1'b1;
         case ({push_ok, pop_ok})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
      end
   end

   // R6
   full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (full && push && !pop) |=> $stable(cnt));
endmodule

// File: rtl/ir_carrier_gen.sv
module ir_carrier_gen #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hi_wr,
   input  logic             lo_wr,
   input  logic [CNT_W-1:0] wval,
   input  logic             restart,
   output logic             carr,
   output logic [CNT_W-1:0] hi_sh,
   output logic [CNT_W-1:0] lo_sh,
   output logic             busy_hi,
   output logic             busy_lo
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   initial begin
      cnt_w_chk: assert ((CNT_W >= 2) && (CNT_W <= 32))
         else $error("ir_carrier_gen: CNT_W out of range");
   end

   logic [CNT_W-1:0] act_lo, cnt;
   logic             phase_hi, take;
   logic [CNT_W-1:0] hi_ld, lo_ld;

   assign hi_ld = (hi_sh == '0) ? ONE : hi_sh;
   assign lo_ld = (lo_sh == '0) ? ONE : lo_sh;
   assign take  = restart || (!phase_hi && cnt == '0);
   assign carr  = phase_hi;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_sh    <= ONE;
         lo_sh    <= ONE;
         act_lo   <= ONE;
         cnt      <= '0;
         phase_hi <= 1'b1;
         busy_hi  <= 1'b0;
         busy_lo  <= 1'b0;
      end else begin
         if (hi_wr) begin
            hi_sh   <= wval;
            busy_hi <= 1'b1;
         end else if (take) begin
            busy_hi <= 1'b0;
         end
         if (lo_wr) begin
            lo_sh   <= wval;
            busy_lo <= 1'b1;
         end else if (take) begin
            busy_lo <= 1'b0;
         end
         if (take) begin
            act_lo   <= lo_ld;
            phase_hi <= 1'b1;
            cnt      <= hi_ld - ONE;
         end else if (cnt == '0) begin
            phase_hi <= 1'b0;
            cnt      <= act_lo - ONE;
         end else begin
            cnt <= cnt - ONE;
         end
      end
   end

   // R3
   restart_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> carr);
   // R10
   hi_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hi_wr |=> busy_hi);
endmodule

// File: rtl/ir_irq_unit.sv
module ir_irq_unit #(
   parameter int N = 5
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] evt,
   input  logic [N-1:0] en_set,
   input  logic [N-1:0] en_clr,
   input  logic [N-1:0] ack,
   input  logic [N-1:0] frc,
   output logic [N-1:0] raw,
   output logic [N-1:0] en,
   output logic         irq
);
   genvar g;
   generate
      for (g = 0; g < N; g++) begin : g_src
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               raw[g] <= 1'b0;
               en[g]  <= 1'b0;
            end else begin
               if (evt[g] || frc[g]) raw[g] <= 1'b1;
               else if (ack[g])      raw[g] <= 1'b0;
               if (en_set[g])        en[g]  <= 1'b1;
               else if (en_clr[g])   en[g]  <= 1'b0;
            end
         end
      end
   endgenerate

   assign irq = |(raw & en);

   // R9
   force_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (frc != '0) |=> ((raw & $past(frc)) == $past(frc)));
   // R9
   ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((ack != '0) && (evt == '0) && (frc == '0)) |=> ((raw & $past(ack)) == '0));
endmodule

// File: rtl/ir_carrier_mod.sv
module ir_carrier_mod
   import ir_mod_pkg::*;
#(
   parameter int DEPTH = 8,
   parameter int CNT_W = 16,
   parameter int DIV_W = 16,
   localparam int LVL_W = $clog2(DEPTH + 1)
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_en,
   input  logic [3:0]  wr_addr,
   input  logic [31:0] wr_data,
   input  logic [3:0]  rd_addr,
   output logic [31:0] rd_data,
   output logic        ir_out,
   output logic        irq
);
   localparam logic [DIV_W-1:0] DIV_ONE = DIV_W'(1);
   localparam logic [DUR_W-1:0] DUR_ONE = DUR_W'(1);

   initial begin
      div_w_chk: assert ((DIV_W >= 2) && (DIV_W <= 32) && (CNT_W <= 32))
         else $error("ir_carrier_mod: counter width out of range");
   end

   wire unused_bits = ^wr_data[FORCE_BIT-1:DUR_W];

   // register strobes
   logic w_push, w_hi, w_lo, w_div;
   logic [NUM_IRQ-1:0] s_set, s_clr, s_ack, s_frc;
   assign w_push = wr_en && (wr_addr == A_PUSH);
   assign w_hi   = wr_en && (wr_addr == A_CARR_HI);
   assign w_lo   = wr_en && (wr_addr == A_CARR_LO);
   assign w_div  = wr_en && (wr_addr == A_BIT_DIV);
   assign s_set  = (wr_en && wr_addr == A_EN_SET)    ? wr_data[NUM_IRQ-1:0] : '0;
   assign s_clr  = (wr_en && wr_addr == A_EN_CLR)    ? wr_data[NUM_IRQ-1:0] : '0;
   assign s_ack  = (wr_en && wr_addr == A_IRQ_ACK)   ? wr_data[NUM_IRQ-1:0] : '0;
   assign s_frc  = (wr_en && wr_addr == A_IRQ_FORCE) ? wr_data[NUM_IRQ-1:0] : '0;

   // queue
   instr_t           head;
   logic [LVL_W-1:0] q_level;
   logic             q_empty, q_full, q_half, pop;

   ir_tx_fifo #(.DEPTH(DEPTH), .W(ENTRY_W)) u_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (w_push),
      .din   (pack_word(wr_data)),
      .pop   (pop),
      .dout  (head),
      .level (q_level),
      .empty (q_empty),
      .full  (q_full),
      .half  (q_half)
   );

   // sequencer state
   logic             run, cur_active, cur_forced, busy_div;
   logic [DUR_W-1:0] dur_left;
   logic [DIV_W-1:0] div_cnt, div_sh, div_ld;
   logic             end_now, load, div_take, restart;

   assign div_ld   = (div_sh == '0) ? DIV_ONE : div_sh;
   assign end_now  = run && (dur_left == DUR_ONE) && (div_cnt == '0);
   assign pop      = (!run || end_now) && !q_empty;
   assign load     = pop && head.valid;
   assign div_take = !run || (div_cnt == '0);
   assign restart  = load && head.active && !head.forced;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run        <= 1'b0;
         cur_active <= 1'b0;
         cur_forced <= 1'b0;
         dur_left   <= '0;
         div_cnt    <= '0;
         div_sh     <= DIV_ONE;
         busy_div   <= 1'b0;
      end else begin
         if (w_div) begin
            div_sh   <= wr_data[DIV_W-1:0];
            busy_div <= 1'b1;
         end else if (div_take) begin
            busy_div <= 1'b0;
         end
         if (load) begin
            run        <= 1'b1;
            cur_active <= head.active;
            cur_forced <= head.forced;
            dur_left   <= (head.dur == '0) ? DUR_ONE : head.dur;
            div_cnt    <= div_ld - DIV_ONE;
         end else if (end_now) begin
            run <= 1'b0;
         end else if (run) begin
            if (div_cnt == '0) begin
               div_cnt  <= div_ld - DIV_ONE;
               dur_left <= dur_left - DUR_ONE;
            end else begin
               div_cnt <= div_cnt - DIV_ONE;
            end
         end
      end
   end

   // carrier
   logic             carr, busy_hi, busy_lo;
   logic [CNT_W-1:0] hi_sh, lo_sh;

   ir_carrier_gen #(.CNT_W(CNT_W)) u_carr (
      .clk     (clk),
      .rst_n   (rst_n),
      .hi_wr   (w_hi),
      .lo_wr   (w_lo),
      .wval    (wr_data[CNT_W-1:0]),
      .restart (restart),
      .carr    (carr),
      .hi_sh   (hi_sh),
      .lo_sh   (lo_sh),
      .busy_hi (busy_hi),
      .busy_lo (busy_lo)
   );

   assign ir_out = run && cur_active && (cur_forced || carr);

   // interrupt sources
   logic               full_q, empty_q, half_q;
   logic [NUM_IRQ-1:0] evt, raw, en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         full_q  <= 1'b0;
         empty_q <= 1'b1;
         half_q  <= 1'b1;
      end else begin
         full_q  <= q_full;
         empty_q <= q_empty;
         half_q  <= q_half;
      end
   end

   always_comb begin
      evt                = '0;
      evt[IRQ_FRAME_END] = end_now && !load;
      evt[IRQ_UNDERFLOW] = end_now && q_empty;
      evt[IRQ_FULL]      = q_full && !full_q;
      evt[IRQ_EMPTY]     = q_empty && !empty_q;
      evt[IRQ_HALF]      = q_half && !half_q;
   end

   ir_irq_unit #(.N(NUM_IRQ)) u_irq (
      .clk    (clk),
      .rst_n  (rst_n),
      .evt    (evt),
      .en_set (s_set),
      .en_clr (s_clr),
      .ack    (s_ack),
      .frc    (s_frc),
      .raw    (raw),
      .en     (en),
      .irq    (irq)
   );

   // read mux
   always_comb begin
      rd_data = '0;
      case (rd_addr)
         A_CARR_HI:   rd_data = 32'(hi_sh);
         A_CARR_LO:   rd_data = 32'(lo_sh);
         A_BIT_DIV:   rd_data = 32'(div_sh);
         A_FIFO_STAT: begin
            rd_data[7:0] = 8'(q_level);
            rd_data[8]   = q_empty;
            rd_data[9]   = q_full;
            rd_data[10]  = q_half;
         end
         A_IRQ_PEND:  rd_data = 32'(raw & en);
         A_IRQ_RAW:   rd_data = 32'(raw);
         A_IRQ_EN:    rd_data = 32'(en);
         A_UPD_BUSY:  rd_data = {29'd0, busy_div, busy_lo, busy_hi};
         default:     rd_data = '0;
      endcase
   end

   // R1
   invalid_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && pop && !head.valid) |=> !run);
   // R2
   forced_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (load && head.active && head.forced) |=> ir_out);
   // R4
   end_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(run) |-> ($past(dur_left) == DUR_ONE && $past(div_cnt) == '0));
   // R10
   div_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      w_div |=> busy_div);
endmodule

// File: tb/ir_carrier_mod_test.sv
module ir_carrier_mod_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [3:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic [3:0]  rd_addr = '0;
   logic [31:0] rd_data;
   logic        ir_out, irq;

   int checks = 0;
   int errors = 0;
   logic [31:0] samp;

   ir_carrier_mod uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
      .ir_out(ir_out), .irq(irq)
   );

   always #5 clk = ~clk;

   function automatic logic [31:0] mk(input bit v, input bit a, input bit f, input int d);
      return {v, a, f, 11'd0, 18'(d)};
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   // back-to-back write: drives now, returns at the next falling edge
   task automatic wr_now(input logic [3:0] a, input logic [31:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] d);
      rd_addr = a;
      #1;
      d = rd_data;
   endtask

   task automatic capture(input int n);
      samp = '0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         samp[i] = ir_out;
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic t_reset;
      logic [31:0] d;
      chk("R5 reset output", 32'(ir_out), 0);
      chk("R9 reset irq", 32'(irq), 0);
      rd(4'd4, d); chk("R6 reset queue status", d, 32'h500);
      rd(4'd12, d); chk("R10 reset busy", d, 0);
   endtask

   task automatic t_forced;
      wr(4'd10, 32'h1F);
      wr(4'd3, 2);
      idle(3);
      wr_now(4'd0, mk(1, 1, 1, 3));
      capture(10);
      chk("R2 R4 forced-high span", samp, 32'h3F);
   endtask

   task automatic t_inactive;
      logic [31:0] d;
      wr(4'd10, 32'h1F);
      wr_now(4'd0, mk(1, 0, 1, 2));
      capture(6);
      chk("R2 inactive low", samp, 0);
      idle(3);
      rd(4'd6, d); chk("R8 R7 end with empty queue raw", d, 32'h0D);
   endtask

   task automatic t_terminator;
      logic [31:0] d;
      wr(4'd10, 32'h1F);
      wr(4'd8, 32'h01);
      @(negedge clk);
      wr_now(4'd0, mk(1, 1, 1, 2));
      wr_now(4'd0, mk(0, 0, 0, 0));
      idle(8);
      rd(4'd6, d); chk("R8 terminator no underflow", d, 32'h09);
      chk("R9 frame end irq", 32'(irq), 1);
      wr(4'd9, 32'h01);
      wr(4'd10, 32'h1F);
   endtask

   task automatic t_invalid;
      logic [31:0] d;
      @(negedge clk);
      wr_now(4'd0, mk(0, 1, 1, 5));
      capture(12);
      chk("R1 invalid word no output", samp, 0);
      rd(4'd4, d); chk("R1 invalid word consumed", d & 32'hFF, 0);
      rd(4'd6, d); chk("R1 invalid word no frame end", d & 32'h05, 0);
   endtask

   task automatic t_carrier;
      logic [31:0] d;
      wr(4'd1, 2);
      wr(4'd2, 3);
      wr(4'd3, 3);
      idle(12);
      rd(4'd12, d); chk("R10 carrier updates taken", d, 0);
      @(negedge clk);
      wr_now(4'd0, mk(1, 1, 0, 2));
      fork
         wr_now(4'd0, mk(1, 1, 0, 1));
         capture(12);
      join
      chk("R3 carrier pattern and restart", samp, 32'hE3);
      idle(4);
   endtask

   task automatic t_chain;
      @(negedge clk);
      wr_now(4'd0, mk(1, 1, 1, 1));
      fork
         begin
            wr_now(4'd0, mk(1, 0, 0, 1));
            wr_now(4'd0, mk(1, 1, 1, 1));
         end
         capture(12);
      join
      chk("R4 chained words without gap", samp, 32'h1C7);
      idle(4);
   endtask

   task automatic t_busy;
      logic [31:0] d;
      wr(4'd1, 4);
      rd(4'd12, d); chk("R10 high count pending", d & 32'h1, 1);
      idle(20);
      rd(4'd12, d); chk("R10 high count taken", d, 0);
      rd(4'd1, d); chk("R10 high count readback", d, 4);
      wr(4'd3, 2);
      rd(4'd12, d); chk("R10 divider pending", d, 4);
      idle(2);
      rd(4'd12, d); chk("R10 divider taken while idle", d, 0);
      wr(4'd1, 2);
      idle(20);
   endtask

   task automatic t_full;
      logic [31:0] d;
      wr(4'd10, 32'h1F);
      wr(4'd3, 2);
      wr(4'd0, mk(1, 1, 1, 200));
      idle(2);
      for (int i = 0; i < 8; i++) wr(4'd0, mk(1, 0, 0, 1));
      rd(4'd4, d); chk("R6 queue full status", d, 32'h208);
      idle(2);
      rd(4'd6, d); chk("R7 full raw bit", d & 32'h2, 32'h2);
      wr(4'd0, mk(1, 0, 0, 1));
      rd(4'd4, d); chk("R6 push into full dropped", d, 32'h208);
      wr(4'd10, 32'h1F);
      idle(500);
      rd(4'd6, d); chk("R7 drain raw bits", d, 32'h1D);
      rd(4'd4, d); chk("R6 drained status", d, 32'h500);
   endtask

   task automatic t_irq;
      logic [31:0] d;
      wr(4'd10, 32'h1F);
      wr(4'd11, 32'h08);
      chk("R9 forced raw without enable", 32'(irq), 0);
      wr(4'd8, 32'h08);
      chk("R9 irq after enable", 32'(irq), 1);
      rd(4'd7, d); chk("R9 enable readback", d, 32'h08);
      rd(4'd5, d); chk("R9 pending", d, 32'h08);
      wr(4'd9, 32'h08);
      chk("R9 irq after disable", 32'(irq), 0);
      rd(4'd6, d); chk("R9 raw kept after disable", d, 32'h08);
      wr(4'd8, 32'h08);
      wr(4'd10, 32'h08);
      chk("R9 irq after acknowledge", 32'(irq), 0);
      rd(4'd6, d); chk("R9 raw after acknowledge", d, 0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(2);
      t_reset();
      t_forced();
      t_inactive();
      t_terminator();
      t_invalid();
      t_carrier();
      t_chain();
      t_busy();
      t_full();
      t_irq();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule